// File: doc/BRIEF.md
# Polyphase Decimate-by-Three FIR Filter

This block lowers the sample rate of a stream of signed fixed-point samples by a factor of three while low-pass filtering it with a six-tap FIR. Samples arrive with a strobe at the high rate. The block emits one filtered sample, with a single-cycle strobe of its own, for every three samples it accepts.

The six taps are split into three two-tap branches. Branch 0 uses taps 0 and 3, branch 1 uses taps 1 and 4, and branch 2 uses taps 2 and 5. Each branch sees the input delayed by its branch index and reduced to one sample in three. Each branch holds one low-rate delay between its two taps. Samples are only held while a group of three builds up. The multiplies run once per output, when the group completes, so the results that would be thrown away are never formed.

The branch results are summed at full precision. The sum is rounded to the output width and clamped on overflow. The coefficients and the widths are parameters.

Top module: `polydec3`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` goes low and `out_data` goes to zero at that edge. All stored samples and the group phase are cleared, so after reset every earlier sample counts as zero.
- R2: Accepted samples are numbered t = 0, 1, 2, ... from reset. `out_valid` is high for exactly one cycle, in the cycle after each sample with t mod 3 = 2 is accepted. It is low in every other cycle.
- R3: On each `out_valid` pulse, `out_data` equals the direct-form result y(t) = sum over k = 0..5 of Hk * x(t-k), for the sample t that completed the group. This result is then rounded per R4 and saturated per R5.
- R4: Rounding adds 2^(FRAC-1) to the full-precision sum and then shifts it arithmetically right by FRAC bits. Exact halves therefore round toward plus infinity.
- R5: A rounded value above 2^(OW-1)-1 is output as 2^(OW-1)-1. A rounded value below -2^(OW-1) is output as -2^(OW-1).
- R6: `out_data` keeps its last value in every cycle in which `out_valid` is low.
- R7: In a cycle where `in_valid` is low, `in_data` has no effect on any later output, and the group phase does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_data` carries a sample |
| in_data | input | DW | High-rate sample, two's complement |
| out_valid | output | 1 | Single-cycle strobe for a new output |
| out_data | output | OW | Filtered, decimated sample, two's complement |

## Verification
The assertions assume only that `in_valid` is a clean level sampled at the clock edge. They also assume that reset is held for more than one edge before it is released, so that `out_data` has a defined value before it is checked for stability. The bench holds reset for several cycles at start-up and once more in mid-run. It drives and changes inputs only on falling edges, and it fills cycles with `in_valid` low with random `in_data`. Its random phase mixes back-to-back samples with irregular gaps. Its directed phases cover impulses at each group position, exact-half rounding ties, and full-scale steps that drive the output into both clamps.

// File: rtl/polydec3.sv
module polydec3 #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int OW   = 16,
  parameter int FRAC = 15,
  parameter logic signed [CW-1:0] H0 = 16'sd8192,
  parameter logic signed [CW-1:0] H1 = 16'sd16384,
  parameter logic signed [CW-1:0] H2 = 16'sd24576,
  parameter logic signed [CW-1:0] H3 = 16'sd24576,
  parameter logic signed [CW-1:0] H4 = 16'sd16384,
  parameter logic signed [CW-1:0] H5 = -16'sd8192
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int PW = DW + CW;
  localparam int AW = PW + 3;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (OW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  logic [1:0] phase;
  logic signed [DW-1:0] cur0, cur1;
  logic signed [DW-1:0] old0, old1, old2;

  wire done = in_valid && (phase == 2'd2);

  logic signed [PW-1:0] m0, m1, m2, m3, m4, m5;
  assign m0 = in_data * H0;
  assign m3 = old0 * H3;
  assign m1 = cur1 * H1;
  assign m4 = old1 * H4;
  assign m2 = cur0 * H2;
  assign m5 = old2 * H5;

  logic signed [AW-1:0] br0, br1, br2, acc, rnd, shr;
  assign br0 = AW'(m0) + AW'(m3);
  assign br1 = AW'(m1) + AW'(m4);
  assign br2 = AW'(m2) + AW'(m5);
  assign acc = br0 + br1 + br2;
  assign rnd = acc + HALF;
  assign shr = rnd >>> FRAC;

  logic signed [OW-1:0] sat;
  always_comb begin
    if (shr > MAXV)      sat = MAXV[OW-1:0];
    else if (shr < MINV) sat = MINV[OW-1:0];
    else                 sat = shr[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      cur0      <= '0;
      cur1      <= '0;
      old0      <= '0;
      old1      <= '0;
      old2      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= done;
      if (in_valid) begin
        case (phase)
          2'd0:    begin cur0 <= in_data; phase <= 2'd1; end
          2'd1:    begin cur1 <= in_data; phase <= 2'd2; end
          default: begin
            old0     <= in_data;
            old1     <= cur1;
            old2     <= cur0;
            out_data <= sat;
            phase    <= 2'd0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/polydec3_chk.sv
module polydec3_chk #(
  parameter int OW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_data
);
  logic [1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (in_valid) seen <= (seen == 2'd2) ? 2'd0 : seen + 2'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);
  a_r2_group_phase:  assert property (@(posedge clk) disable iff (rst) out_valid |-> (seen == 2'd0 && $past(in_valid)));
  a_r7_idle_no_out:  assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  a_r6_hold_value:   assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(out_data));
endmodule

bind polydec3 polydec3_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_polydec3.sv
module sim_polydec3;
  localparam int CLK_PERIOD = 10;
  localparam int FRAC = 15;
  localparam longint HMAX = 32767;
  localparam longint HMIN = -32768;
  localparam longint HK [6] = '{8192, 16384, 24576, 24576, 16384, -8192};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;

  int checks = 0;
  int errors = 0;
  longint hist [6];
  int cnt = 0;
  longint last_out = 0;

  polydec3 #(
    .DW(16), .CW(16), .OW(16), .FRAC(FRAC),
    .H0(16'sd8192), .H1(16'sd16384), .H2(16'sd24576),
    .H3(16'sd24576), .H4(16'sd16384), .H5(-16'sd8192)
  ) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint round_sat(input longint a);
    longint r;
    r = (a + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    if (r > HMAX) r = HMAX;
    if (r < HMIN) r = HMIN;
    return r;
  endfunction

  function automatic longint expect_now();
    longint a = 0;
    for (int k = 0; k < 6; k++) a += HK[k] * hist[k];
    return a;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", longint'(out_valid), 0);
    check("R1 out_data in reset", longint'(out_data), 0);
    rst = 1'b0;
    for (int k = 0; k < 6; k++) hist[k] = 0;
    cnt = 0;
    last_out = 0;
  endtask

  task automatic push(input longint v, input string tag);
    longint e, raw;
    in_valid = 1'b1;
    in_data = 16'(v);
    for (int k = 5; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    cnt = (cnt + 1) % 3;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 16'($urandom);
    if (cnt == 0) begin
      raw = expect_now();
      e = round_sat(raw);
      check("R2 strobe on third sample", longint'(out_valid), 1);
      check(tag, longint'(out_data), e);
      last_out = e;
    end else begin
      check("R2 no strobe mid-group", longint'(out_valid), 0);
      check("R6 hold mid-group", longint'(out_data), last_out);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_data = 16'($urandom);
    @(negedge clk);
    check("R7 idle gives no strobe", longint'(out_valid), 0);
    check("R6 idle hold", longint'(out_data), last_out);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    for (int k = 0; k < 6; k++) hist[k] = 0;
    @(negedge clk);
    do_reset();

    // R3 impulses at each group position
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 9; i++) push((i == p) ? 1000 : 0, "R3 impulse");
      idle();
    end

    // R4 rounding ties and fractions
    push(0, "R4 tie"); push(1, "R4 tie"); push(0, "R4 tie up");
    push(0, "R4 tie"); push(0, "R4 tie"); push(0, "R4 flush");
    push(0, "R4 tie"); push(-1, "R4 tie"); push(0, "R4 tie neg");
    push(1, "R4 frac"); push(0, "R4 frac"); push(0, "R4 frac");
    push(-1, "R4 frac"); push(0, "R4 frac"); push(0, "R4 frac neg");

    // R7 ignored data between samples, then R5 clamps
    idle(); idle();
    for (int i = 0; i < 9; i++) push(32767, "R5 positive clamp");
    for (int i = 0; i < 9; i++) push(-32768, "R5 negative clamp");
    for (int i = 0; i < 6; i++) push(0, "R3 step back to zero");

    // R1 mid-group reset: held samples must be forgotten
    push(20000, "R1 pre"); push(-20000, "R1 pre");
    do_reset();
    push(0, "R1 after reset"); push(0, "R1 after reset"); push(0, "R1 zero after reset");
    push(500, "R1"); push(0, "R1"); push(0, "R1 fresh only");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      longint v;
      case ($urandom % 8)
        0: v = 32767;
        1: v = -32768;
        default: v = longint'($signed(16'($urandom)));
      endcase
      if ($urandom % 4 == 0) idle();
      push(v, "R3 random");
    end

    finish_run();
  end
endmodule